// File: doc/BRIEF.md
# Interrupt Source and Mask Aggregator

This block gathers one-cycle event pulses from the endpoint, buffer, disk-interface and bus-event logic of a USB mass-storage controller. It latches them into two 8-bit status registers. A mask register sits beside each status register, and the block combines each pair into one active-high interrupt line for the embedded CPU. Firmware reads the status registers and acknowledges events by writing ones to them. While an endpoint's receive or transmit status is pending, the block also drives a hold line to that endpoint so that the endpoint refuses further tokens.

Some bits are not plain latches. One bit in the first register is a live view of the separate bus-event register. One bit in the second register is a live view of a disk-transfer completion flag. Two bits always read zero. A repeated SETUP packet forces a one-cycle dip in its status bit so that an edge-sensitive CPU input sees a new rising edge. The buffer-write completion bits may be cleared by hardware while automatic transfer mode is on. A suspend bit sets after a programmable number of clocks of continuous bus idle.

Register select on `reg_addr`: 0 = status A, 1 = mask A, 2 = status B, 3 = mask B. Status A bits: 0 endpoint-0 receive, 1 endpoint-0 transmit, 2 buffer-A read done, 3 buffer-B read done, 4 disk interrupt, 5 reserved, 6 SETUP, 7 bus-event summary. Status B bits: 0 endpoint-1 receive, 1 endpoint-1 transmit, 2 buffer-A write done, 3 buffer-B write done, 4 suspend, 5 transfer-complete view, 6 reserved, 7 bulk NAK event.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, status A reads 0x0C, status B reads 0x00, both masks read 0xFF, and both interrupt lines are low.
- R2: An event pulse sets its status bit on the next clock edge whatever the mask. An interrupt line is high exactly when some status bit of its register is 1 and the matching mask bit is 0.
- R3: A write of 1 to a status bit clears it and a write of 0 leaves it unchanged. When a write clears a bit on the same edge that an event sets it, the bit ends up set.
- R4: Status A bit 7 always equals `bus_evt_pending`. Writes to it have no effect, and it drives `irq0` when unmasked.
- R5: Status A bit 5 and status B bit 6 always read 0. Status B bit 5 always equals `xfer_done_flag` and writes do not change it.
- R6: A SETUP pulse that arrives while status A bit 6 is 1 makes that bit read 0 for exactly one cycle and then 1 again.
- R7: `nak_rx[i]` and `nak_tx[i]` equal the receive and transmit status bits of endpoint i (bits 0 and 1 of status A for i=0, and of status B for i=1).
- R8: `wr_hw_clr[j]` clears status B bit 2+j only while `auto_mode` is 1. A `wr_done[j]` pulse on the same edge wins over the clear.
- R9: Status B bit 4 sets on the edge that completes IDLE_CYCLES consecutive clocks of `bus_idle`. It sets once per idle period, and any non-idle clock restarts the count.
- R10: Each mask register reads back all 8 bits last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the register selected by reg_addr |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ep_rx_done | input | 2 | Receive-complete pulse per endpoint (0, 1) |
| ep_tx_done | input | 2 | Transmit-complete pulse per endpoint (0, 1) |
| rd_done | input | 2 | Buffer A/B read-complete pulses |
| wr_done | input | 2 | Buffer A/B write-complete pulses |
| ata_evt | input | 1 | Disk interrupt pulse |
| setup_evt | input | 1 | SETUP packet received pulse |
| bulk_nak_evt | input | 1 | Bulk NAK event pulse |
| bus_evt_pending | input | 1 | Level: any bus-event status pending |
| xfer_done_flag | input | 1 | Level: disk transfer complete |
| bus_idle | input | 1 | Level: bus idle this clock |
| auto_mode | input | 1 | Automatic transfer mode active |
| wr_hw_clr | input | 2 | Hardware clear of the buffer A/B write-complete bits |
| irq0 | output | 1 | Interrupt from status A |
| irq1 | output | 1 | Interrupt from status B |
| nak_rx | output | 2 | Receive hold per endpoint |
| nak_tx | output | 2 | Transmit hold per endpoint |

## Verification
Every latched status bit, the SETUP dip and its recovery, and the hardware clear take effect on the first rising edge after the stimulus. The bench drives inputs on a falling edge and reads one falling edge later. Reads, the live bits, the hold lines and the interrupt lines follow the registers combinationally, so they are sampled a little after the address or level changes. The SETUP dip is checked on two successive falling edges to pin it to one cycle. Suspend is checked one clock before and on the IDLE_CYCLES-th idle edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int IDLE_CYCLES = 180000,
  localparam int CW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] ep_rx_done,
  input  logic [1:0] ep_tx_done,
  input  logic [1:0] rd_done,
  input  logic [1:0] wr_done,
  input  logic       ata_evt,
  input  logic       setup_evt,
  input  logic       bulk_nak_evt,
  input  logic       bus_evt_pending,
  input  logic       xfer_done_flag,
  input  logic       bus_idle,
  input  logic       auto_mode,
  input  logic [1:0] wr_hw_clr,
  output logic       irq0,
  output logic       irq1,
  output logic [1:0] nak_rx,
  output logic [1:0] nak_tx
);
  localparam logic [7:0] KEEP0 = 8'h5F;
  localparam logic [7:0] KEEP1 = 8'h9F;

  logic [7:0] sa_q, sb_q, ma_q, mb_q;
  logic       resetup_q;
  logic [CW-1:0] idle_cnt;
  logic       idle_hit;

  wire wr_sa = reg_wr && reg_addr == 2'd0;
  wire wr_ma = reg_wr && reg_addr == 2'd1;
  wire wr_sb = reg_wr && reg_addr == 2'd2;
  wire wr_mb = reg_wr && reg_addr == 2'd3;
  wire dup_setup = setup_evt && sa_q[6];

  wire [7:0] set_a = {3'b000, ata_evt, rd_done, ep_tx_done[0], ep_rx_done[0]};
  wire [7:0] set_b = {bulk_nak_evt, 2'b00, idle_hit, wr_done, ep_tx_done[1], ep_rx_done[1]};
  wire [7:0] clr_a = wr_sa ? reg_wdata : 8'h00;
  wire [7:0] clr_b = (wr_sb ? reg_wdata : 8'h00) | {4'h0, wr_hw_clr & {2{auto_mode}}, 2'b00};

  logic [7:0] sa_d;
  always_comb begin
    sa_d = ((sa_q & ~clr_a) | set_a) & KEEP0;
    if (dup_setup) sa_d[6] = 1'b0;
    else if (setup_evt || resetup_q) sa_d[6] = 1'b1;
  end

  assign idle_hit = bus_idle && idle_cnt == CW'(IDLE_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q      <= 8'h0C;
      sb_q      <= 8'h00;
      ma_q      <= 8'hFF;
      mb_q      <= 8'hFF;
      resetup_q <= 1'b0;
      idle_cnt  <= '0;
    end else begin
      sa_q      <= sa_d;
      sb_q      <= ((sb_q & ~clr_b) | set_b) & KEEP1;
      resetup_q <= dup_setup;
      if (wr_ma) ma_q <= reg_wdata;
      if (wr_mb) mb_q <= reg_wdata;
      if (!bus_idle) idle_cnt <= '0;
      else if (idle_cnt != CW'(IDLE_CYCLES)) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  wire [7:0] view_a = {bus_evt_pending, sa_q[6], 1'b0, sa_q[4:0]};
  wire [7:0] view_b = {sb_q[7], 1'b0, xfer_done_flag, sb_q[4:0]};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = view_a;
      2'd1:    reg_rdata = ma_q;
      2'd2:    reg_rdata = view_b;
      default: reg_rdata = mb_q;
    endcase
  end

  assign irq0   = |(view_a & ~ma_q);
  assign irq1   = |(view_b & ~mb_q);
  assign nak_rx = {sb_q[0], sa_q[0]};
  assign nak_tx = {sb_q[1], sa_q[1]};
endmodule

module irq_aggregator_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic [1:0] ep_rx_done,
  input logic       setup_evt,
  input logic       bus_evt_pending,
  input logic       irq0,
  input logic       irq1,
  input logic [1:0] nak_rx,
  input logic [7:0] sa_q,
  input logic [7:0] ma_q,
  input logic [7:0] mb_q
);
  AST_RX_SETS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ep_rx_done[0] |=> nak_rx[0]); // R2
  AST_IRQ0_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> ma_q != 8'hFF); // R2
  AST_IRQ1_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> mb_q != 8'hFF); // R2
  AST_BUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[7] == bus_evt_pending); // R4
  AST_RESERVED_A: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> !reg_rdata[5]); // R5
  AST_RESERVED_B: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd2 |-> !reg_rdata[6]); // R5
  AST_SETUP_DIP: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && sa_q[6] |=> !sa_q[6]); // R6
  AST_SETUP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sa_q[6]) && $past(setup_evt) |=> sa_q[6]); // R6
endmodule

bind irq_aggregator irq_aggregator_checks i_checks (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ep_rx_done(ep_rx_done), .setup_evt(setup_evt), .bus_evt_pending(bus_evt_pending),
  .irq0(irq0), .irq1(irq1), .nak_rx(nak_rx), .sa_q(sa_q), .ma_q(ma_q), .mb_q(mb_q)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int IDLE = 40;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] ep_rx_done = 0, ep_tx_done = 0, rd_done = 0, wr_done = 0, wr_hw_clr = 0;
  logic ata_evt = 0, setup_evt = 0, bulk_nak_evt = 0;
  logic bus_evt_pending = 0, xfer_done_flag = 0, bus_idle = 0, auto_mode = 0;
  logic irq0, irq1;
  logic [1:0] nak_rx, nak_tx;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_aggregator #(.IDLE_CYCLES(IDLE)) i_irq_aggregator (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rchk(string tag, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); chk(tag, v, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic t_reset;
    rchk("R1 status A", 0, 8'h0C);
    rchk("R1 mask A", 1, 8'hFF);
    rchk("R1 status B", 2, 8'h00);
    rchk("R1 mask B", 3, 8'hFF);
    chk("R1 irq0", irq0, 0);
    chk("R1 irq1", irq1, 0);
  endtask

  task automatic t_set_mask_clear;
    ep_rx_done[0] = 1; @(negedge clk); ep_rx_done[0] = 0;
    rchk("R2 set while masked", 0, 8'h0D);
    chk("R2 masked irq0 low", irq0, 0);
    chk("R7 nak_rx0 held", nak_rx[0], 1);
    wr(1, 8'hFE);
    chk("R2 unmasked irq0 high", irq0, 1);
    wr(0, 8'h00);
    rchk("R3 write zero no effect", 0, 8'h0D);
    wr(0, 8'h01);
    rchk("R3 write one clears", 0, 8'h0C);
    chk("R2 irq0 drops", irq0, 0);
    chk("R7 nak_rx0 released", nak_rx[0], 0);
    ep_tx_done = 2'b10; @(negedge clk); ep_tx_done = 0;
    chk("R7 nak_tx1 held", nak_tx[1], 1);
    wr(2, 8'h02);
    chk("R7 nak_tx1 released", nak_tx[1], 0);
    wr(0, 8'h0C);
    rchk("R3 clear read-done bits", 0, 8'h00);
    wr(1, 8'hFF);
  endtask

  task automatic t_set_wins;
    ep_rx_done[1] = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 8'h01;
    @(negedge clk); ep_rx_done[1] = 0; reg_wr = 0; reg_wdata = 0;
    rchk("R3 set beats clear", 2, 8'h01);
    wr(2, 8'h01);
    rchk("R3 cleared afterwards", 2, 8'h00);
  endtask

  task automatic t_mirror;
    bus_evt_pending = 1; #1;
    rchk("R4 mirror high", 0, 8'h80);
    wr(0, 8'h80);
    rchk("R4 write ignored", 0, 8'h80);
    chk("R4 masked no irq", irq0, 0);
    wr(1, 8'h7F);
    chk("R4 unmasked irq0", irq0, 1);
    bus_evt_pending = 0; #1;
    chk("R4 irq0 follows level", irq0, 0);
    wr(1, 8'hFF);
  endtask

  task automatic t_reserved;
    ata_evt = 1; rd_done = 2'b11; ep_rx_done = 2'b11; ep_tx_done = 2'b11;
    wr_done = 2'b11; bulk_nak_evt = 1;
    @(negedge clk);
    ata_evt = 0; rd_done = 0; ep_rx_done = 0; ep_tx_done = 0; wr_done = 0; bulk_nak_evt = 0;
    rchk("R5 status A bit5 zero", 0, 8'h1F);
    rchk("R5 status B bit6 zero", 2, 8'h8F);
    xfer_done_flag = 1; #1;
    rchk("R5 view high", 2, 8'hAF);
    wr(2, 8'hFF);
    rchk("R5 view survives write", 2, 8'h20);
    xfer_done_flag = 0; #1;
    rchk("R5 view low", 2, 8'h00);
    wr(0, 8'hFF);
    rchk("R3 all cleared", 0, 8'h00);
  endtask

  task automatic t_setup;
    wr(1, 8'hBF);
    setup_evt = 1; @(negedge clk); setup_evt = 0;
    rchk("R6 first setup", 0, 8'h40);
    chk("R6 irq0 high", irq0, 1);
    setup_evt = 1; @(negedge clk); setup_evt = 0;
    rchk("R6 dip low", 0, 8'h00);
    chk("R6 irq0 dips", irq0, 0);
    @(negedge clk);
    rchk("R6 back high", 0, 8'h40);
    chk("R6 irq0 rises again", irq0, 1);
    @(negedge clk);
    rchk("R6 stays high", 0, 8'h40);
    wr(0, 8'h40);
    rchk("R6 cleared", 0, 8'h00);
    wr(1, 8'hFF);
  endtask

  task automatic t_auto;
    wr_done = 2'b01; @(negedge clk); wr_done = 0;
    rchk("R8 write-done set", 2, 8'h04);
    wr_hw_clr = 2'b01; @(negedge clk); wr_hw_clr = 0;
    rchk("R8 no clear outside auto", 2, 8'h04);
    auto_mode = 1; wr_hw_clr = 2'b01; @(negedge clk); wr_hw_clr = 0;
    rchk("R8 hardware clear", 2, 8'h00);
    wr_done = 2'b10; wr_hw_clr = 2'b10; @(negedge clk); wr_done = 0; wr_hw_clr = 0;
    rchk("R8 set beats hardware clear", 2, 8'h08);
    auto_mode = 0;
    wr(2, 8'h08);
  endtask

  task automatic t_suspend;
    bus_idle = 1;
    repeat (IDLE - 1) @(negedge clk);
    rchk("R9 not yet", 2, 8'h00);
    @(negedge clk);
    rchk("R9 set at limit", 2, 8'h10);
    wr(2, 8'h10);
    repeat (IDLE + 5) @(negedge clk);
    rchk("R9 once per idle period", 2, 8'h00);
    bus_idle = 0; @(negedge clk);
    bus_idle = 1; repeat (20) @(negedge clk);
    bus_idle = 0; @(negedge clk);
    bus_idle = 1; repeat (IDLE - 1) @(negedge clk);
    rchk("R9 count restarted", 2, 8'h00);
    @(negedge clk);
    rchk("R9 set after restart", 2, 8'h10);
    bus_idle = 0;
    wr(2, 8'h10);
  endtask

  task automatic t_mask_rb;
    wr(3, 8'h5A);
    rchk("R10 mask B readback", 3, 8'h5A);
    wr(1, 8'hA5);
    rchk("R10 mask A readback", 1, 8'hA5);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_mask_clear();
    t_set_wins();
    t_mirror();
    t_reserved();
    t_setup();
    t_auto();
    t_suspend();
    t_mask_rb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule